// File: doc/BRIEF.md
# Decoded Memory Subsystem with Zero-Forced OR Read Bus

This block gives an 8-bit CPU core with a 16-bit address bus its on-chip memory. From the CPU address it selects one of three synchronous memories: a small RAM for the first page of the address space, a RAM for the stack page and a boot ROM at the top of the map. The CPU supplies an address, a write strobe and write data on every clock. One cycle later it gets back a single read byte.

None of the memories drives a shared bus through tristate buffers, and there is no multiplexer choosing between them. A memory whose region is not addressed loads zero into its output register. The byte returned to the CPU is the bitwise OR of every memory output. The region decode is registered together with the read, so the clearing of an output happens in the same cycle as the data it replaces. The ROM contents come from a computed table, and the top of that table holds the reset vector.

Top module: `cpu_mem_sys`

## Requirements
- R1: While `rst_n` is low, `rdata` is 0x00, and it stays 0x00 until the first clock edge after release that reads a mapped location.
- R2: A read has one cycle of latency: the `rdata` that follows a clock edge belongs to the address, strobe and data sampled on that edge, whatever the region of the access before it.
- R3: Addresses 0x0000 to 0x00FF reach a 256-byte RAM indexed by address bits [7:0]. A write stores `wdata`, and a later read of the same address returns it.
- R4: Addresses 0x0100 to 0x01FF reach a 1K-entry stack RAM indexed by address bits [9:0]. A write stores `wdata`, and a later read returns it.
- R5: Addresses 0xF000 to 0xFFFF read the ROM at offset o = address bits [11:0]. The byte at offset 0xFFC is 0x00 and the byte at offset 0xFFD is 0xF0, giving a reset vector of 0xF000. Every other offset holds o[7:0] XOR {o[11:8], o[11:8]}.
- R6: Any address outside the three regions reads as 0x00.
- R7: On a write edge to a RAM, that RAM's output register is not updated and every other memory outputs zero. The next `rdata` is therefore the byte that RAM returned on the previous edge, or 0x00 if the previous access was to another region.
- R8: A write to the ROM region or to an unmapped address changes no memory. For a write to the ROM region, `rdata` on the next cycle is the ROM byte for that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| addr | input | 16 | CPU address |
| we | input | 1 | Write strobe, high for a write cycle |
| wdata | input | 8 | Data to be written |
| rdata | output | 8 | Read byte, the OR of all memory output registers |

## Verification
The bench writes to each RAM and reads the data back, including the first and last index of each RAM. Reads that move to a different region on every cycle show whether the registered select clears the right output in the right cycle and whether stale data leaks into the OR. Reads of the reset vector, of other ROM offsets and of unmapped holes on both sides of each region separate decode errors from table errors. Writes that follow reads of the same RAM and of other regions, and writes aimed at the ROM and at unmapped space, test the hold and ignore behaviour.

// File: rtl/mem_sys_pkg.sv
package mem_sys_pkg;

  localparam logic [7:0] ZP_PAGE   = 8'h00;
  localparam logic [7:0] STK_PAGE  = 8'h01;
  localparam logic [3:0] ROM_NIB   = 4'hF;
  localparam logic [11:0] VEC_LO_OFS = 12'hFFC;
  localparam logic [11:0] VEC_HI_OFS = 12'hFFD;
  localparam logic [7:0]  VEC_LO_VAL = 8'h00;
  localparam logic [7:0]  VEC_HI_VAL = 8'hF0;

  typedef struct packed {
    logic zp;
    logic stk;
    logic rom;
  } region_sel_t;

  function automatic logic [7:0] rom_byte(input logic [11:0] ofs);
    logic [7:0] val;
    if (ofs == VEC_LO_OFS)      val = VEC_LO_VAL;
    else if (ofs == VEC_HI_OFS) val = VEC_HI_VAL;
    else                        val = ofs[7:0] ^ {ofs[11:8], ofs[11:8]};
    return val;
  endfunction

endpackage

// File: rtl/msys_decode.sv
module msys_decode
  import mem_sys_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_sel_t       sel
);

  localparam int PAGE_LSB = 8;
  localparam int NIB_LSB  = ADDR_W - 4;

  always_comb begin
    sel     = '0;
    sel.zp  = (addr[ADDR_W-1:PAGE_LSB] == {{(ADDR_W-PAGE_LSB-8){1'b0}}, ZP_PAGE});
    sel.stk = (addr[ADDR_W-1:PAGE_LSB] == {{(ADDR_W-PAGE_LSB-8){1'b0}}, STK_PAGE});
    sel.rom = (addr[ADDR_W-1:NIB_LSB] == ROM_NIB);
  end

endmodule

// File: rtl/msys_ram.sv
module msys_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              wr_en;
  logic              rd_en;

  assign wr_en = sel & we;
  // Output register loads on a read or a clear; holds on a write.
  assign rd_en = ~wr_en;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  always_comb begin
    if (!sel) rd_d = {DATA_W{1'b0}};
    else      rd_d = mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= {DATA_W{1'b0}};
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;

endmodule

// File: rtl/msys_rom.sv
module msys_rom
  import mem_sys_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_d, rd_q;
  logic [11:0]       ofs;

  generate
    if (IDX_W >= 12) begin : g_trunc
      assign ofs = idx[11:0];
    end else begin : g_ext
      assign ofs = {{(12-IDX_W){1'b0}}, idx};
    end
  endgenerate

  always_comb begin
    if (!sel) rd_d = {DATA_W{1'b0}};
    else      rd_d = DATA_W'(rom_byte(ofs));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= {DATA_W{1'b0}};
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

endmodule

// File: rtl/cpu_mem_sys.sv
module cpu_mem_sys
  import mem_sys_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int ZP_DEPTH  = 256,
  parameter int STK_DEPTH = 1024,
  parameter int ROM_IDX_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int ZP_IW  = $clog2(ZP_DEPTH);
  localparam int STK_IW = $clog2(STK_DEPTH);
  localparam int N_SRC  = 3;

  region_sel_t       sel;
  logic [DATA_W-1:0] src [N_SRC];
  logic [DATA_W-1:0] or_acc;

  msys_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  msys_ram #(.DEPTH(ZP_DEPTH), .DATA_W(DATA_W)) u_zp (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel.zp),
    .we    (we),
    .idx   (addr[ZP_IW-1:0]),
    .wdata (wdata),
    .rdata (src[0])
  );

  msys_ram #(.DEPTH(STK_DEPTH), .DATA_W(DATA_W)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel.stk),
    .we    (we),
    .idx   (addr[STK_IW-1:0]),
    .wdata (wdata),
    .rdata (src[1])
  );

  msys_rom #(.DATA_W(DATA_W), .IDX_W(ROM_IDX_W)) u_rom (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel.rom),
    .idx   (addr[ROM_IDX_W-1:0]),
    .rdata (src[2])
  );

  // Deselected sources are zero, so a plain OR forms the read bus.
  always_comb begin
    or_acc = {DATA_W{1'b0}};
    for (int i = 0; i < N_SRC; i++) or_acc = or_acc | src[i];
  end

  assign rdata = or_acc;

endmodule

// File: rtl/msys_chk.sv
module msys_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        we,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata
);

  logic mapped;
  assign mapped = (addr[15:9] == 7'd0) || (addr[15:12] == 4'hF);

  // R1: output is zero while reset is held
  always_comb begin
    if (rst_n == 1'b0) a_r1_reset_zero: assert (rdata == 8'h00);
  end

  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> rdata == 8'h00);

  a_r5_vec_lo: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 16'hFFFC |=> rdata == 8'h00);

  a_r5_vec_hi: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 16'hFFFD |=> rdata == 8'hF0);

  a_r3_zp_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[15:8] == 8'h00) ##1 (!we && addr == $past(addr))
      |=> rdata == $past(wdata, 2));

  a_r4_stk_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[15:8] == 8'h01) ##1 (!we && addr == $past(addr))
      |=> rdata == $past(wdata, 2));

endmodule

bind cpu_mem_sys msys_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .addr  (addr),
  .we    (we),
  .wdata (wdata),
  .rdata (rdata)
);

// File: tb/tb_cpu_mem_sys.sv
module tb_cpu_mem_sys;

  localparam time CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic        we;
  logic [7:0]  wdata;
  logic [7:0]  rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] zp_m  [256];
  logic [7:0] stk_m [1024];
  logic [7:0] zq, sq, rq;

  cpu_mem_sys dut (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .we    (we),
    .wdata (wdata),
    .rdata (rdata)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] rom_ref(input logic [15:0] a);
    logic [11:0] o;
    o = a[11:0];
    if (o == 12'hFFC) return 8'h00;
    if (o == 12'hFFD) return 8'hF0;
    return o[7:0] ^ {o[11:8], o[11:8]};
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h rdata=%h expected=%h", tag, addr, rdata, exp);
    end
  endtask

  // One CPU cycle: drive, clock, update model, compare half a period later.
  task automatic step(input logic [15:0] a, input logic w, input logic [7:0] d,
                      input string tag);
    addr = a; we = w; wdata = d;
    @(posedge clk);
    if (a[15:8] == 8'h00) begin
      if (w) zp_m[a[7:0]] = d; else zq = zp_m[a[7:0]];
    end else zq = 8'h00;
    if (a[15:8] == 8'h01) begin
      if (w) stk_m[a[9:0]] = d; else sq = stk_m[a[9:0]];
    end else sq = 8'h00;
    rq = (a[15:12] == 4'hF) ? rom_ref(a) : 8'h00;
    @(negedge clk);
    check(zq | sq | rq, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    zq = 8'h00; sq = 8'h00; rq = 8'h00;
    rst_n = 1'b0; addr = 16'h0000; we = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    check(8'h00, "R1 in reset");
    rst_n = 1'b1;
    check(8'h00, "R1 after release");
    step(16'h8000, 1'b0, 8'h00, "R1 first read unmapped");

    // R3 zero page write/read, both ends
    step(16'h0000, 1'b1, 8'h11, "R3 write 00");
    step(16'h007F, 1'b1, 8'hA5, "R3 write 7F");
    step(16'h00FF, 1'b1, 8'h3C, "R3 write FF");
    step(16'h0000, 1'b0, 8'h00, "R3 read 00");
    step(16'h00FF, 1'b0, 8'h00, "R3 read FF");
    step(16'h007F, 1'b0, 8'h00, "R3 read 7F");

    // R4 stack page
    step(16'h0100, 1'b1, 8'h5A, "R4 write 100");
    step(16'h01FF, 1'b1, 8'hC3, "R4 write 1FF");
    step(16'h0180, 1'b1, 8'h96, "R4 write 180");
    step(16'h0100, 1'b0, 8'h00, "R4 read 100");
    step(16'h01FF, 1'b0, 8'h00, "R4 read 1FF");
    step(16'h0180, 1'b0, 8'h00, "R4 read 180");

    // R5 ROM table and reset vector
    step(16'hFFFC, 1'b0, 8'h00, "R5 vector low");
    step(16'hFFFD, 1'b0, 8'h00, "R5 vector high");
    step(16'hF000, 1'b0, 8'h00, "R5 ofs 000");
    step(16'hF123, 1'b0, 8'h00, "R5 ofs 123");
    step(16'hFFFF, 1'b0, 8'h00, "R5 ofs FFF");
    step(16'hFABE, 1'b0, 8'h00, "R5 ofs ABE");

    // R6 unmapped holes beside each region
    step(16'h0200, 1'b0, 8'h00, "R6 0200");
    step(16'hEFFF, 1'b0, 8'h00, "R6 EFFF");
    step(16'h8001, 1'b0, 8'h00, "R6 8001");

    // R2 region changes every cycle
    step(16'h00FF, 1'b0, 8'h00, "R2 zp");
    step(16'h0100, 1'b0, 8'h00, "R2 stk");
    step(16'hF000, 1'b0, 8'h00, "R2 rom");
    step(16'h0000, 1'b0, 8'h00, "R2 zp");
    step(16'h4000, 1'b0, 8'h00, "R2 hole");
    step(16'h01FF, 1'b0, 8'h00, "R2 stk");
    step(16'h007F, 1'b0, 8'h00, "R2 zp");

    // R7 write cycle holds the written RAM's register
    step(16'h0010, 1'b1, 8'h77, "R7 zp write after zp read");
    step(16'h0010, 1'b0, 8'h00, "R7 readback");
    step(16'hF123, 1'b0, 8'h00, "R7 rom read");
    step(16'h0011, 1'b1, 8'h22, "R7 zp write after rom read");
    step(16'h0180, 1'b0, 8'h00, "R7 stk read");
    step(16'h0181, 1'b1, 8'h44, "R7 stk write after stk read");
    step(16'h0181, 1'b0, 8'h00, "R7 stk readback");

    // R8 ignored writes
    step(16'hF000, 1'b1, 8'hEE, "R8 write rom");
    step(16'hF000, 1'b0, 8'h00, "R8 rom unchanged");
    step(16'h0200, 1'b1, 8'hAA, "R8 write hole");
    step(16'h0200, 1'b0, 8'h00, "R8 hole reads zero");
    step(16'h0000, 1'b0, 8'h00, "R8 zp 00 unchanged");
    step(16'h0100, 1'b0, 8'h00, "R8 stk 100 unchanged");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule